// File: doc/BRIEF.md
# Static Backward-Taken Branch Direction Predictor

This block sits at the fetch end of a five-stage in-order pipeline. It makes the direction guess for each branch and controls the flush when that guess is wrong. Fetch pre-decodes each instruction and reports whether it is a branch. It also supplies the sign-extended byte offset of that branch. The block decides from the offset's sign alone: a branch that points backwards is guessed taken, and any other branch is guessed not taken. It drives a two-bit select for the PC multiplexer and the next fetch address that the select implies. Ordinary instructions advance by one instruction word, and that address is ready in the same cycle so the next fetch can use it.

On the clock edge after a branch is fetched, the branch reaches decode. There the comparator reports whether it is really taken. When that outcome disagrees with the guess, the block raises a one-cycle mispredict pulse and moves fetch onto the correct path in that same cycle. The only instruction on the wrong path is the one fetched during that cycle. One cycle later, while that instruction sits in decode, the block raises a one-cycle squash request. Pipeline control uses it to pass a no-op into execute in its place, with the memory and writeback enables and the branch signal cleared. The wrongly fetched instruction also never counts as a branch in the block's own decode record, so it cannot raise a second mispredict.

Top module: `bt_guess_unit`

## Requirements
- R1: Directly after reset, and before any branch has been fetched, `mispredict` and `squash_dx` are 0.
- R2: When no branch is being redirected and the fetched slot is not a valid branch, `pc_sel` is 0 (sequential) and `next_pc` is `fetch_pc` + 4.
- R3: A valid fetched branch with `fetch_off[W-1]` = 1 (backward) gives `pc_sel` = 1 (guessed target) and `next_pc` = `fetch_pc` + `fetch_off`, unless a redirect is active.
- R4: A valid fetched branch with `fetch_off[W-1]` = 0, including an offset of zero, is guessed not taken: `pc_sel` = 0 and `next_pc` = `fetch_pc` + 4.
- R5: `mispredict` is 1 in the cycle after a valid branch is fetched exactly when `dec_taken` differs from the guess, and 0 in every other cycle.
- R6: A branch guessed taken that resolves not taken gives, in its mispredict cycle, `pc_sel` = 2 and `next_pc` = that branch's PC + 4, and this overrides the current fetch slot.
- R7: A branch guessed not taken that resolves taken gives, in its mispredict cycle, `pc_sel` = 3 and `next_pc` = that branch's PC + its offset, and this overrides the current fetch slot.
- R8: `squash_dx` is 1 for exactly one cycle, the cycle right after each mispredict, and 0 otherwise.
- R9: A branch fetched during a mispredict cycle is on the wrong path. In the next cycle it raises no mispredict and no redirect, whatever `dec_taken` is.
- R10: `dec_taken` has no effect on `mispredict`, `pc_sel` or `next_pc` when decode holds no valid branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Fetch slot holds a real instruction |
| fetch_br | input | 1 | Pre-decode marks the fetched instruction as a conditional branch |
| fetch_pc | input | W | Address of the fetched instruction |
| fetch_off | input | W | Sign-extended byte offset of the fetched branch |
| dec_taken | input | 1 | Comparator outcome for the instruction now in decode |
| pc_sel | output | 2 | PC mux select: 0 sequential, 1 guessed target, 2 fix to fall-through, 3 fix to target |
| next_pc | output | W | Next fetch address implied by `pc_sel` |
| mispredict | output | 1 | One-cycle pulse when the decode branch disagrees with its guess |
| squash_dx | output | 1 | One-cycle request to pass a no-op from decode to execute |

## Verification
The bench targets the shadow of a mispredict. It places a branch right behind a wrong guess and gives it the outcome that would be a second mispredict. A design that did not kill the wrong-path slot would pulse twice and steer fetch off the correct path. Zero offsets and the most negative offset probe the sign decision: a design that treated zero as backward, or used a magnitude test, would pick the wrong select. Random comparator values while decode holds no branch catch any redirect that does not check for a valid branch. Checking the squash cycle by cycle exposes a squash that comes in the mispredict cycle itself, or one that lasts two cycles.

// File: rtl/bt_guess_unit.sv
`timescale 1ns/1ps
module bt_guess_unit #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fetch_vld,
  input  logic         fetch_br,
  input  logic [W-1:0] fetch_pc,
  input  logic [W-1:0] fetch_off,
  input  logic         dec_taken,
  output logic [1:0]   pc_sel,
  output logic [W-1:0] next_pc,
  output logic         mispredict,
  output logic         squash_dx
);
  localparam logic [1:0]   SEL_SEQ     = 2'd0;
  localparam logic [1:0]   SEL_GUESS   = 2'd1;
  localparam logic [1:0]   SEL_FIX_SEQ = 2'd2;
  localparam logic [1:0]   SEL_FIX_TGT = 2'd3;
  localparam logic [W-1:0] STEP_V      = W'(STEP);

  logic         f_branch, f_guess;
  logic [W-1:0] f_seq, f_tgt;
  logic         d_branch, d_guess, sq_q;
  logic [W-1:0] d_seq, d_tgt;

  assign f_branch   = fetch_vld & fetch_br;
  assign f_guess    = f_branch & fetch_off[W-1];
  assign f_seq      = fetch_pc + STEP_V;
  assign f_tgt      = fetch_pc + fetch_off;
  assign mispredict = d_branch & (dec_taken ^ d_guess);
  assign squash_dx  = sq_q;

  always_comb begin
    if (mispredict)   pc_sel = dec_taken ? SEL_FIX_TGT : SEL_FIX_SEQ;
    else if (f_guess) pc_sel = SEL_GUESS;
    else              pc_sel = SEL_SEQ;
  end

  always_comb begin
    case (pc_sel)
      SEL_GUESS:   next_pc = f_tgt;
      SEL_FIX_SEQ: next_pc = d_seq;
      SEL_FIX_TGT: next_pc = d_tgt;
      default:     next_pc = f_seq;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_branch <= 1'b0;
      d_guess  <= 1'b0;
      d_seq    <= '0;
      d_tgt    <= '0;
      sq_q     <= 1'b0;
    end else begin
      d_branch <= f_branch & ~mispredict;
      d_guess  <= f_guess;
      d_seq    <= f_seq;
      d_tgt    <= f_tgt;
      sq_q     <= mispredict;
    end
  end
endmodule

module bt_guess_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fetch_vld,
  input logic         fetch_br,
  input logic [W-1:0] fetch_off,
  input logic [1:0]   pc_sel,
  input logic         mispredict,
  input logic         squash_dx
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!mispredict && !squash_dx));

  assert_no_double_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> !mispredict);

  assert_squash_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> squash_dx);

  assert_squash_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash_dx |-> $past(mispredict));

  assert_fix_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> pc_sel[1]);

  assert_no_fix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mispredict |-> !pc_sel[1]);

  assert_backward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mispredict && fetch_vld && fetch_br && fetch_off[W-1]) |-> pc_sel == 2'd1);

  assert_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mispredict && !(fetch_vld && fetch_br && fetch_off[W-1])) |-> pc_sel == 2'd0);
endmodule

bind bt_guess_unit bt_guess_unit_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_br(fetch_br),
  .fetch_off(fetch_off), .pc_sel(pc_sel), .mispredict(mispredict),
  .squash_dx(squash_dx)
);

// File: tb/test_bt_guess_unit.sv
`timescale 1ns/1ps
module test_bt_guess_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_vld = 1'b0, fetch_br = 1'b0, dec_taken = 1'b0;
  logic [W-1:0] fetch_pc = '0, fetch_off = '0;
  logic [1:0]   pc_sel;
  logic [W-1:0] next_pc;
  logic         mispredict, squash_dx;

  int n_checks = 0;
  int n_fail   = 0;

  logic         m_br = 0, m_guess = 0, m_sq = 0, m_inj = 0;
  logic [W-1:0] m_seq = '0, m_tgt = '0;

  always #4 clk = ~clk;

  bt_guess_unit #(.W(W), .STEP(4)) i_bt_guess_unit (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_br(fetch_br),
    .fetch_pc(fetch_pc), .fetch_off(fetch_off), .dec_taken(dec_taken),
    .pc_sel(pc_sel), .next_pc(next_pc), .mispredict(mispredict),
    .squash_dx(squash_dx)
  );

  task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(logic mis, logic tk, logic guess);
    if (mis) return tk ? 2'd3 : 2'd2;
    return guess ? 2'd1 : 2'd0;
  endfunction

  task automatic step(logic v, logic b, logic [W-1:0] pc, logic [W-1:0] off, logic tk);
    logic mis, guess;
    logic [1:0] es;
    logic [W-1:0] en;
    string t_sel, t_mis;
    @(negedge clk);
    fetch_vld = v; fetch_br = b; fetch_pc = pc; fetch_off = off; dec_taken = tk;
    #2;
    mis   = m_br && (tk != m_guess);
    guess = v && b && off[W-1];
    es    = exp_sel(mis, tk, guess);
    case (es)
      2'd1: en = pc + off;
      2'd2: en = m_seq;
      2'd3: en = m_tgt;
      default: en = pc + 32'd4;
    endcase
    if (mis)              t_sel = tk ? "R7" : "R6";
    else if (v && b)      t_sel = off[W-1] ? "R3" : "R4";
    else                  t_sel = "R2";
    if (m_sq)             t_mis = "R9";
    else if (!m_br)       t_mis = "R10";
    else                  t_mis = "R5";
    check(t_mis, "mispredict", W'(mispredict), W'(mis));
    check(t_sel, "pc_sel", W'(pc_sel), W'(es));
    check(t_sel, "next_pc", next_pc, en);
    check("R8", "squash_dx", W'(squash_dx), W'(m_inj));
    m_sq    = v && b && mis;
    m_br    = v && b && !mis;
    m_guess = guess;
    m_seq   = pc + 32'd4;
    m_tgt   = pc + off;
    m_inj   = mis;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] pc;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "mispredict", W'(mispredict), 0);
    check("R1", "squash_dx", W'(squash_dx), 0);

    step(1, 0, 32'h100, 32'h0, 1);
    step(1, 1, 32'h104, 32'hFFFF_FFF0, 0);
    step(1, 0, 32'h108, 32'h0, 1);
    step(1, 0, 32'h10C, 32'h0, 0);
    step(1, 1, 32'h200, 32'h0000_0040, 1);
    step(1, 1, 32'h204, 32'hFFFF_FF00, 1);
    step(1, 0, 32'h240, 32'h0, 0);
    step(1, 1, 32'h300, 32'h0, 0);
    step(1, 1, 32'h304, 32'h0, 0);
    step(1, 1, 32'h400, 32'h8000_0000, 1);
    step(0, 1, 32'h404, 32'hFFFF_FFFC, 1);
    step(1, 0, 32'h408, 32'h0, 1);
    step(1, 1, 32'h40C, 32'hFFFF_FFFC, 1);
    step(1, 1, 32'h410, 32'h0000_0010, 1);
    step(1, 0, 32'h414, 32'h0, 1);

    pc = 32'h1000;
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] off;
      logic v, b, tk;
      v   = ($urandom % 8) != 0;
      b   = ($urandom % 2) == 0;
      tk  = $urandom % 2;
      off = W'(signed'(($urandom % 512) - 256)) << 2;
      step(v, b, pc, off, tk);
      pc = next_pc;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule